// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block collects eight asynchronous interrupt request lines and turns them into a pending-request vector for a downstream priority resolver. Each line has its own trigger mode, chosen at run time through a byte-wide trigger-mode register. A line in edge mode latches a request when its input rises and holds it until the resolver acknowledges it. A line in level mode simply mirrors its synchronized input.

Every input passes through a two-stage synchronizer before any edge detection. The resolver acknowledges one line at a time with a strobe and a 3-bit line number. The acknowledge clears only requests that an edge captured. A level request stays asserted for as long as its pin stays high.

The trigger-mode register can be written over a byte port and is always visible on an output. Each instance has a fixed mask that decides which of its mode bits are writable.

Top module: `irq_req_latch`

## Requirements
- R1: After reset, asserted low on `rst_n`, both `pendingReq` and `trigMode` read 8'h00. A mode bit of 0 selects edge mode and a mode bit of 1 selects level mode.
- R2: For a line whose mode bit is 1, `pendingReq[i]` equals the value `reqIn[i]` had three rising clock edges earlier (two synchronizer stages plus the request register). The bit clears when the input goes low.
- R3: For a line whose mode bit is 0, a low-to-high change on `reqIn[i]` sets `pendingReq[i]` on the third rising clock edge after the change.
- R4: For an edge-mode line, the input falling does not clear `pendingReq[i]`. An input held high produces no further request once the held request has been acknowledged; a new request needs the input to go low and then high again.
- R5: A cycle with `ackValid` high and `ackNum` = n clears `pendingReq[n]` at the next clock edge when line n is in edge mode. No other bit changes.
- R6: An acknowledge of a level-mode line has no effect on its request bit.
- R7: When the rising-edge detection and an acknowledge for the same edge-mode line fall in the same cycle, the request bit stays set.
- R8: A cycle with `cfgWrEn` high loads `trigMode` with `cfgWrData` ANDed with the instance parameter `MODE_WRITE_MASK`. With `cfgWrEn` low, `trigMode` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqIn | input | 8 | Asynchronous interrupt request lines |
| ackValid | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| ackNum | input | 3 | Number of the line being acknowledged |
| cfgWrEn | input | 1 | Write strobe for the trigger-mode register |
| cfgWrData | input | 8 | Write data for the trigger-mode register |
| pendingReq | output | 8 | Pending-request vector sent to the resolver |
| trigMode | output | 8 | Trigger-mode register read-back (1 = level) |

## Verification
On every cycle, the assertions check the per-bit update rule of the request register: level bits follow the synchronized input, edge bits are set by a rise, hold without an acknowledge, and clear on an acknowledge that comes without a rise. They also check the masked mode-register load. Only the bench's scenarios show the end-to-end behaviour at the pins. That covers the three-edge latency from the pins, the absence of a second request while an input stays high, and a mode change in the middle of a sequence. It also covers the exact coincidence of a new edge with an acknowledge, and the mask on a second instance with a narrower writable set.

// File: rtl/irq_req_latch_pkg.sv
package irq_req_latch_pkg;
  localparam int LINE_COUNT = 8;
  localparam int LINE_IDX_W = $clog2(LINE_COUNT);

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [LINE_COUNT-1:0] level;   // synchronized input level
    logic [LINE_COUNT-1:0] rise;    // one-cycle rising-edge pulse
    logic [LINE_COUNT-1:0] ackHit;  // one-hot decoded acknowledge
    logic                  cfgLoad;
    logic [LINE_COUNT-1:0] cfgData;
  } latch_strobe_t;
endpackage

// File: rtl/irq_req_latch_ctrl.sv
module irq_req_latch_ctrl
  import irq_req_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINE_COUNT-1:0] reqIn,
  input  logic                  ackValid,
  input  logic [LINE_IDX_W-1:0] ackNum,
  input  logic                  cfgWrEn,
  input  logic [LINE_COUNT-1:0] cfgWrData,
  output latch_strobe_t         strobes
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [LINE_COUNT-1:0] syncChain [SYNC_STAGES];
  logic [LINE_COUNT-1:0] lastLevel;
  logic [LINE_COUNT-1:0] syncLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= reqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncLevel = syncChain[LAST_STAGE];

  // record of the previously seen synchronized level, kept in every mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastLevel <= '0;
    else        lastLevel <= syncLevel;
  end

  always_comb begin
    strobes.level   = syncLevel;
    strobes.rise    = syncLevel & ~lastLevel;
    strobes.ackHit  = ackValid ? (LINE_COUNT'(1) << ackNum) : '0;
    strobes.cfgLoad = cfgWrEn;
    strobes.cfgData = cfgWrData;
  end

  // a rise pulse never lasts two cycles (R4: held-high input gives no repeat)
  generate
    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_chk
      p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.rise[i] |=> !strobes.rise[i]);
    end
  endgenerate

  // acknowledge decode targets at most one line (R5)
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.ackHit));
endmodule

// File: rtl/irq_req_latch_dp.sv
module irq_req_latch_dp
  import irq_req_latch_pkg::*;
#(
  parameter logic [LINE_COUNT-1:0] MODE_WRITE_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  latch_strobe_t         strobes,
  output logic [LINE_COUNT-1:0] pendingReq,
  output logic [LINE_COUNT-1:0] trigMode
);
  logic [LINE_COUNT-1:0] pendNext;
  logic [LINE_COUNT-1:0] edgeKeep;

  // edge lines: a new rise wins over an acknowledge in the same cycle
  assign edgeKeep = strobes.rise | (pendingReq & ~strobes.ackHit);
  assign pendNext = (trigMode & strobes.level) | (~trigMode & edgeKeep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendingReq <= '0;
    else        pendingReq <= pendNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               trigMode <= '0;
    else if (strobes.cfgLoad) trigMode <= strobes.cfgData & MODE_WRITE_MASK;
  end

  generate
    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_chk
      p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trigMode[i] |=> pendingReq[i] == $past(strobes.level[i]));
      p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trigMode[i] && strobes.rise[i]) |=> pendingReq[i]);
      p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trigMode[i] && pendingReq[i] && !strobes.ackHit[i]) |=> pendingReq[i]);
      p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trigMode[i] && strobes.ackHit[i] && !strobes.rise[i]) |=> !pendingReq[i]);
      p_ack_vs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trigMode[i] && strobes.ackHit[i] && strobes.rise[i]) |=> pendingReq[i]);
    end
  endgenerate

  p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cfgLoad |=> trigMode == ($past(strobes.cfgData) & MODE_WRITE_MASK));
  p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.cfgLoad |=> $stable(trigMode));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_req_latch_pkg::*;
#(
  parameter logic [LINE_COUNT-1:0] MODE_WRITE_MASK = '1,
  parameter int                    SYNC_STAGES     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINE_COUNT-1:0] reqIn,
  input  logic                  ackValid,
  input  logic [LINE_IDX_W-1:0] ackNum,
  input  logic                  cfgWrEn,
  input  logic [LINE_COUNT-1:0] cfgWrData,
  output logic [LINE_COUNT-1:0] pendingReq,
  output logic [LINE_COUNT-1:0] trigMode
);
  latch_strobe_t strobes;

  irq_req_latch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .ackValid(ackValid),
    .ackNum(ackNum), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .strobes(strobes)
  );

  irq_req_latch_dp #(.MODE_WRITE_MASK(MODE_WRITE_MASK)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .pendingReq(pendingReq), .trigMode(trigMode)
  );

  // reset leaves both outputs clear (R1)
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pendingReq == '0 && trigMode == '0) || !rst_n);
endmodule

// File: tb/irq_req_latch_tb_top.sv
module irq_req_latch_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] req;
    logic       doAck;
    logic [2:0] num;
    logic [7:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 1'b0, 3'd0, 8'h00},  // R1 idle
    '{8'h00, 8'h0F, 1'b0, 3'd0, 8'h0F},  // R3 edges latch
    '{8'h00, 8'h00, 1'b0, 3'd0, 8'h0F},  // R4 fall keeps request
    '{8'h00, 8'h00, 1'b1, 3'd1, 8'h0D},  // R5 ack line 1
    '{8'hF0, 8'hF0, 1'b0, 3'd0, 8'hFD},  // R2 level lines high
    '{8'hF0, 8'hF0, 1'b1, 3'd5, 8'hFD},  // R6 ack of level line ignored
    '{8'hF0, 8'h00, 1'b0, 3'd0, 8'h0D},  // R2 level lines drop
    '{8'hF0, 8'h00, 1'b1, 3'd0, 8'h0C},  // R5 ack line 0
    '{8'hF0, 8'h00, 1'b1, 3'd2, 8'h08},  // R5 ack line 2
    '{8'hF0, 8'h00, 1'b1, 3'd3, 8'h00},  // R5 ack line 3
    '{8'h00, 8'h80, 1'b0, 3'd0, 8'h80},  // R3 line 7 edge
    '{8'h00, 8'h80, 1'b1, 3'd7, 8'h00},  // R5 ack line 7
    '{8'h00, 8'h80, 1'b0, 3'd0, 8'h00}   // R4 held high, no repeat
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqIn = '0;
  logic       ackValid = 1'b0;
  logic [2:0] ackNum = '0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] pendingReq, trigMode;
  logic       mWrEn = 1'b0;
  logic [7:0] mWrData = '0;
  logic [7:0] mPending, mMode;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_req_latch dut_i (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .ackValid(ackValid),
    .ackNum(ackNum), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .pendingReq(pendingReq), .trigMode(trigMode)
  );

  irq_req_latch #(.MODE_WRITE_MASK(8'h3C)) dut_m (
    .clk(clk), .rst_n(rst_n), .reqIn(8'h00), .ackValid(1'b0),
    .ackNum(3'd0), .cfgWrEn(mWrEn), .cfgWrData(mWrData),
    .pendingReq(mPending), .trigMode(mMode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeMode(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0; cfgWrData = 8'h55;
  endtask

  task automatic pulseAck(input logic [2:0] n);
    ackValid = 1'b1; ackNum = n;
    @(negedge clk); ackValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitNeg(3);
    check("R1 pending after reset", pendingReq, 8'h00);
    check("R1 mode after reset", trigMode, 8'h00);
    rst_n = 1'b1;
    waitNeg(2);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      writeMode(VECS[v].cfg);
      reqIn = VECS[v].req;
      waitNeg(5);
      if (VECS[v].doAck) pulseAck(VECS[v].num);
      check($sformatf("table row %0d", v), pendingReq, VECS[v].exp);
    end

    // R3 latency: edge line 1 rises, set on third posedge
    reqIn = 8'h00; writeMode(8'h00); waitNeg(4);
    pulseAck(3'd7); waitNeg(1);
    check("R3 clean start", pendingReq, 8'h00);
    reqIn = 8'h02;
    waitNeg(2);
    check("R3 not yet after two edges", pendingReq, 8'h00);
    waitNeg(1);
    check("R3 set on third edge", pendingReq, 8'h02);

    // R2 latency: level line 4
    writeMode(8'h10); waitNeg(3);
    reqIn = 8'h12;
    waitNeg(2);
    check("R2 not yet after two edges", pendingReq, 8'h02);
    waitNeg(1);
    check("R2 follows on third edge", pendingReq, 8'h12);

    // R7: rise and ack on line 6 in the same cycle
    writeMode(8'h00); reqIn = 8'h00; waitNeg(4);
    pulseAck(3'd1); pulseAck(3'd4); waitNeg(1);
    reqIn = 8'h40; waitNeg(4);
    check("R7 first request", pendingReq, 8'h40);
    reqIn = 8'h00; waitNeg(4);
    reqIn = 8'h40;
    waitNeg(2);            // rise pulse is active during the next cycle
    pulseAck(3'd6);
    check("R7 rise beats ack", pendingReq, 8'h40);
    waitNeg(2);
    check("R7 stays set", pendingReq, 8'h40);

    // R8: mask and readback
    writeMode(8'hA5);
    check("R8 readback full mask", trigMode, 8'hA5);
    cfgWrData = 8'hFF; waitNeg(2);
    check("R8 no write without enable", trigMode, 8'hA5);
    @(negedge clk); mWrEn = 1'b1; mWrData = 8'hFF;
    @(negedge clk); mWrEn = 1'b0;
    check("R8 masked write", mMode, 8'h3C);
    check("R8 masked instance idle", mPending, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule